// File: doc/BRIEF.md
# Register-Routed Stream Crossbar

A crossbar that links a set of AXI4-Stream inputs to a set of AXI4-Stream outputs. The routing is not arbitrated. Software fixes it through an AXI4-Lite register file. Each output owns one selector register, which names the input that feeds that output or switches the output off. A path carries every beat of its input unchanged to its output: data, byte keeps, last flag and user bits. Each output has an optional register stage.

Selector writes go to a staged copy. Software applies them by writing the commit bit. The switch then waits until no connected path is part-way through a packet, and only then loads the staged table into the live one. While a commit waits, no path starts a new packet. An input may drive only one output. When several selectors name the same input, the lowest-numbered of those outputs is connected and the others stay idle.

Top module: `stream_xbar`

## Requirements
- R1: The selector of output k is at byte offset 0x04 + 4*k. Bits [7:0] hold the input index and bit 31 is the disable flag. A read returns the staged value, with the other bits zero.
- R2: After reset, every selector reads 0x8000_0000, every output holds TVALID low and every input holds TREADY low.
- R3: An output whose active selector is disabled, or whose index is not below NUM_IN, holds TVALID low and claims no input.
- R4: When several active selectors name the same input, only the lowest-numbered of those outputs carries that input's data. The higher-numbered ones hold TVALID low.
- R5: Writing 1 to bit 0 at offset 0x00 requests a commit. Bit 0 at offset 0x00 reads 1 until the staged table is live and 0 afterwards. Staged writes do not change the live routing before a commit.
- R6: While a connected input is inside a packet (a beat was accepted and its TLAST has not yet been accepted), a pending commit waits and the old routing keeps carrying that packet. The new table takes effect after that TLAST.
- R7: An input that no live path claims holds TREADY low.
- R8: TDATA, TKEEP, TLAST and TUSER pass from input to output unchanged. With OUT_REG=1 they pass through one register stage per output. While an output has TVALID high and TREADY low, its TVALID and TDATA hold steady and the feeding input sees TREADY low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_awaddr_i | input | ADDR_W | Register write address |
| cfg_awvalid_i | input | 1 | Write address valid |
| cfg_awready_o | output | 1 | Write address ready |
| cfg_wdata_i | input | 32 | Write data (full-word writes) |
| cfg_wvalid_i | input | 1 | Write data valid |
| cfg_wready_o | output | 1 | Write data ready |
| cfg_bresp_o | output | 2 | Write response, always OKAY |
| cfg_bvalid_o | output | 1 | Write response valid |
| cfg_bready_i | input | 1 | Write response ready |
| cfg_araddr_i | input | ADDR_W | Register read address |
| cfg_arvalid_i | input | 1 | Read address valid |
| cfg_arready_o | output | 1 | Read address ready |
| cfg_rdata_o | output | 32 | Read data |
| cfg_rresp_o | output | 2 | Read response, always OKAY |
| cfg_rvalid_o | output | 1 | Read data valid |
| cfg_rready_i | input | 1 | Read data ready |
| s_tdata_i | input | NUM_IN*DATA_W | Input stream data, input i at slice i |
| s_tkeep_i | input | NUM_IN*DATA_W/8 | Input byte keeps |
| s_tlast_i | input | NUM_IN | Input end-of-packet flags |
| s_tuser_i | input | NUM_IN*USER_W | Input user sideband |
| s_tvalid_i | input | NUM_IN | Input valid flags |
| s_tready_o | output | NUM_IN | Input ready flags |
| m_tdata_o | output | NUM_OUT*DATA_W | Output stream data, output k at slice k |
| m_tkeep_o | output | NUM_OUT*DATA_W/8 | Output byte keeps |
| m_tlast_o | output | NUM_OUT | Output end-of-packet flags |
| m_tuser_o | output | NUM_OUT*USER_W | Output user sideband |
| m_tvalid_o | output | NUM_OUT | Output valid flags |
| m_tready_i | input | NUM_OUT | Output ready flags |

## Verification
The hardest state to reach is a commit that has to wait. A connected input must be part-way through a packet at the moment the commit is written, so the pending bit can be seen as 1 while the old path is still carrying data. The stimulus holds TLAST low on one routed input while its output accepts beats. It then stages and commits a new selector, reads the pending bit and the old output data, and finally raises TLAST so the switch can change tables. The conflict rule is reached by pointing two selectors at one input. A later commit disables the lower output, and the higher one must then take the path over.

// File: rtl/stream_xbar_pkg.sv
package stream_xbar_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             dis;
    logic [IDX_W-1:0] idx;
  } sel_t;

  localparam sel_t SEL_RESET = '{dis: 1'b1, idx: '0};
endpackage

// File: rtl/stream_xbar_regs.sv
module stream_xbar_regs
  import stream_xbar_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic              busy_i,
  output sel_t [NUM_OUT-1:0] act_o,
  output logic              pending_o
);
  localparam int WA_W = ADDR_W - 2;

  sel_t [NUM_OUT-1:0] shadow_q;
  logic [WA_W-1:0]    waddr, raddr;
  logic               wr_fire, ar_fire, commit_wr;
  logic [1:0]         unused_addr;

  assign waddr       = awaddr_i[ADDR_W-1:2];
  assign raddr       = araddr_i[ADDR_W-1:2];
  assign unused_addr = awaddr_i[1:0] ^ araddr_i[1:0];
  assign wr_fire     = awvalid_i && wvalid_i && !bvalid_o;
  assign awready_o   = wr_fire;
  assign wready_o    = wr_fire;
  assign ar_fire     = arvalid_i && !rvalid_o;
  assign arready_o   = !rvalid_o;
  assign commit_wr   = wr_fire && (waddr == '0) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_o  <= 1'b0;
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      pending_o <= 1'b0;
      for (int k = 0; k < NUM_OUT; k++) begin
        shadow_q[k] <= SEL_RESET;
        act_o[k]    <= SEL_RESET;
      end
    end else begin
      if (wr_fire)       bvalid_o <= 1'b1;
      else if (bready_i) bvalid_o <= 1'b0;

      for (int k = 0; k < NUM_OUT; k++)
        if (wr_fire && int'(waddr) == k + 1)
          shadow_q[k] <= '{dis: wdata_i[31], idx: wdata_i[IDX_W-1:0]};

      // a new request wins over a swap in the same cycle
      if (commit_wr) pending_o <= 1'b1;
      else if (pending_o && !busy_i) begin
        pending_o <= 1'b0;
        act_o     <= shadow_q;
      end

      if (ar_fire) begin
        rvalid_o <= 1'b1;
        rdata_o  <= (raddr == '0) ? {31'b0, pending_o} : 32'b0;
        for (int k = 0; k < NUM_OUT; k++)
          if (int'(raddr) == k + 1)
            rdata_o <= {shadow_q[k].dis, {(31-IDX_W){1'b0}}, shadow_q[k].idx};
      end else if (rready_i) begin
        rvalid_o <= 1'b0;
      end
    end
  end

  a_r5_commit_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !busy_i && !commit_wr |=> !pending_o);

  a_r6_live_table_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && busy_i) || !pending_o |=> $stable(act_o));
endmodule

// File: rtl/stream_xbar_route.sv
module stream_xbar_route
  import stream_xbar_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 16,
  parameter int SRC_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  sel_t [NUM_OUT-1:0]               act_i,
  output logic [NUM_OUT-1:0]               en_o,
  output logic [NUM_OUT-1:0][SRC_W-1:0]    src_o,
  output logic [NUM_IN-1:0][NUM_OUT-1:0]   claim_o
);
  logic [NUM_OUT-1:0] legal;

  always_comb begin
    for (int k = 0; k < NUM_OUT; k++) begin
      legal[k] = !act_i[k].dis && (int'(act_i[k].idx) < NUM_IN);
      src_o[k] = act_i[k].idx[SRC_W-1:0];
    end
    // lowest-numbered output keeps a contested input
    for (int k = 0; k < NUM_OUT; k++) begin
      en_o[k] = legal[k];
      for (int j = 0; j < k; j++)
        if (legal[j] && act_i[j].idx == act_i[k].idx) en_o[k] = 1'b0;
    end
    for (int i = 0; i < NUM_IN; i++)
      for (int k = 0; k < NUM_OUT; k++)
        claim_o[i][k] = en_o[k] && (int'(act_i[k].idx) == i);
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    a_r4_single_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(claim_o[i]));
  end
endmodule

// File: rtl/stream_xbar_ostage.sv
module stream_xbar_ostage #(
  parameter int  DATA_W  = 32,
  parameter int  KEEP_W  = 4,
  parameter int  USER_W  = 2,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [KEEP_W-1:0] in_keep_i,
  input  logic              in_last_i,
  input  logic [USER_W-1:0] in_user_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic [KEEP_W-1:0] m_keep_o,
  output logic              m_last_o,
  output logic [USER_W-1:0] m_user_o,
  output logic              m_valid_o,
  input  logic              m_ready_i
);
  if (OUT_REG) begin : g_reg
    assign in_ready_o = !m_valid_o || m_ready_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         m_valid_o <= 1'b0;
      else if (in_ready_o) m_valid_o <= in_valid_i;
    end

    always_ff @(posedge clk_i) begin
      if (in_ready_o && in_valid_i) begin
        m_data_o <= in_data_i;
        m_keep_o <= in_keep_i;
        m_last_o <= in_last_i;
        m_user_o <= in_user_i;
      end
    end

    a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));
  end else begin : g_pass
    assign in_ready_o = m_ready_i;
    assign m_valid_o  = in_valid_i;
    assign m_data_o   = in_data_i;
    assign m_keep_o   = in_keep_i;
    assign m_last_o   = in_last_i;
    assign m_user_o   = in_user_i;
  end
endmodule

// File: rtl/stream_xbar.sv
module stream_xbar
  import stream_xbar_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 16,
  parameter int DATA_W  = 32,
  parameter int USER_W  = 2,
  parameter int ADDR_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          cfg_awaddr_i,
  input  logic                       cfg_awvalid_i,
  output logic                       cfg_awready_o,
  input  logic [31:0]                cfg_wdata_i,
  input  logic                       cfg_wvalid_i,
  output logic                       cfg_wready_o,
  output logic [1:0]                 cfg_bresp_o,
  output logic                       cfg_bvalid_o,
  input  logic                       cfg_bready_i,
  input  logic [ADDR_W-1:0]          cfg_araddr_i,
  input  logic                       cfg_arvalid_i,
  output logic                       cfg_arready_o,
  output logic [31:0]                cfg_rdata_o,
  output logic [1:0]                 cfg_rresp_o,
  output logic                       cfg_rvalid_o,
  input  logic                       cfg_rready_i,
  input  logic [NUM_IN*DATA_W-1:0]   s_tdata_i,
  input  logic [NUM_IN*DATA_W/8-1:0] s_tkeep_i,
  input  logic [NUM_IN-1:0]          s_tlast_i,
  input  logic [NUM_IN*USER_W-1:0]   s_tuser_i,
  input  logic [NUM_IN-1:0]          s_tvalid_i,
  output logic [NUM_IN-1:0]          s_tready_o,
  output logic [NUM_OUT*DATA_W-1:0]  m_tdata_o,
  output logic [NUM_OUT*DATA_W/8-1:0] m_tkeep_o,
  output logic [NUM_OUT-1:0]         m_tlast_o,
  output logic [NUM_OUT*USER_W-1:0]  m_tuser_o,
  output logic [NUM_OUT-1:0]         m_tvalid_o,
  input  logic [NUM_OUT-1:0]         m_tready_i
);
  localparam int KEEP_W = DATA_W / 8;
  localparam int SRC_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  sel_t [NUM_OUT-1:0]              act;
  logic                            pending, busy;
  logic [NUM_OUT-1:0]              en, stg_rdy;
  logic [NUM_OUT-1:0][SRC_W-1:0]   src;
  logic [NUM_IN-1:0][NUM_OUT-1:0]  claim;
  logic [NUM_IN-1:0]               claimed, hold, in_pkt_q;

  assign cfg_bresp_o = 2'b00;
  assign cfg_rresp_o = 2'b00;

  stream_xbar_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .awaddr_i (cfg_awaddr_i), .awvalid_i(cfg_awvalid_i), .awready_o(cfg_awready_o),
    .wdata_i  (cfg_wdata_i),  .wvalid_i (cfg_wvalid_i),  .wready_o (cfg_wready_o),
    .bvalid_o (cfg_bvalid_o), .bready_i (cfg_bready_i),
    .araddr_i (cfg_araddr_i), .arvalid_i(cfg_arvalid_i), .arready_o(cfg_arready_o),
    .rdata_o  (cfg_rdata_o),  .rvalid_o (cfg_rvalid_o),  .rready_i (cfg_rready_i),
    .busy_i   (busy), .act_o(act), .pending_o(pending)
  );

  stream_xbar_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SRC_W(SRC_W)) u_route (
    .clk_i, .rst_ni, .act_i(act), .en_o(en), .src_o(src), .claim_o(claim)
  );

  // while a commit waits, inputs between packets may not start a new one
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      claimed[i]    = |claim[i];
      hold[i]       = pending && !in_pkt_q[i];
      s_tready_o[i] = 1'b0;
      for (int k = 0; k < NUM_OUT; k++)
        if (claim[i][k] && stg_rdy[k] && !hold[i]) s_tready_o[i] = 1'b1;
    end
  end

  assign busy = |(in_pkt_q & claimed);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_pkt_q <= '0;
    else
      for (int i = 0; i < NUM_IN; i++)
        if (s_tvalid_i[i] && s_tready_o[i]) in_pkt_q[i] <= !s_tlast_i[i];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic [SRC_W-1:0] sk;
    logic             in_v;
    assign sk   = src[k];
    assign in_v = en[k] && s_tvalid_i[sk] && !hold[sk];

    stream_xbar_ostage #(
      .DATA_W(DATA_W), .KEEP_W(KEEP_W), .USER_W(USER_W), .OUT_REG(OUT_REG)
    ) u_stage (
      .clk_i, .rst_ni,
      .in_data_i (s_tdata_i[sk*DATA_W +: DATA_W]),
      .in_keep_i (s_tkeep_i[sk*KEEP_W +: KEEP_W]),
      .in_last_i (s_tlast_i[sk]),
      .in_user_i (s_tuser_i[sk*USER_W +: USER_W]),
      .in_valid_i(in_v),
      .in_ready_o(stg_rdy[k]),
      .m_data_o  (m_tdata_o[k*DATA_W +: DATA_W]),
      .m_keep_o  (m_tkeep_o[k*KEEP_W +: KEEP_W]),
      .m_last_o  (m_tlast_o[k]),
      .m_user_o  (m_tuser_o[k*USER_W +: USER_W]),
      .m_valid_o (m_tvalid_o[k]),
      .m_ready_i (m_tready_i[k])
    );
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    a_r7_idle_input_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !claimed[i] |-> !s_tready_o[i]);
  end
endmodule

// File: tb/stream_xbar_bench.sv
module stream_xbar_bench;
  localparam int NI = 16, NO = 16, DW = 32, UW = 2, AW = 8, KW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [NI*DW-1:0] s_tdata;
  logic [NI*KW-1:0] s_tkeep;
  logic [NI-1:0] s_tlast = '1, s_tvalid = '0, s_tready;
  logic [NI*UW-1:0] s_tuser;
  logic [NO*DW-1:0] m_tdata;
  logic [NO*KW-1:0] m_tkeep;
  logic [NO-1:0] m_tlast, m_tvalid, m_tready = '1;
  logic [NO*UW-1:0] m_tuser;

  int n_checks = 0, n_fail = 0;

  stream_xbar #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(DW), .USER_W(UW), .ADDR_W(AW)) u_stream_xbar (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_awaddr_i(awaddr), .cfg_awvalid_i(awvalid), .cfg_awready_o(awready),
    .cfg_wdata_i(wdata), .cfg_wvalid_i(wvalid), .cfg_wready_o(wready),
    .cfg_bresp_o(bresp), .cfg_bvalid_o(bvalid), .cfg_bready_i(1'b1),
    .cfg_araddr_i(araddr), .cfg_arvalid_i(arvalid), .cfg_arready_o(arready),
    .cfg_rdata_o(rdata), .cfg_rresp_o(rresp), .cfg_rvalid_o(rvalid), .cfg_rready_i(1'b1),
    .s_tdata_i(s_tdata), .s_tkeep_i(s_tkeep), .s_tlast_i(s_tlast), .s_tuser_i(s_tuser),
    .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
    .m_tdata_o(m_tdata), .m_tkeep_o(m_tkeep), .m_tlast_o(m_tlast), .m_tuser_o(m_tuser),
    .m_tvalid_o(m_tvalid), .m_tready_i(m_tready)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
  endtask

  task automatic reg_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata;
  endtask

  task automatic commit_and_wait();
    logic [31:0] v;
    reg_write(8'h00, 32'h1);
    v = 32'h1;
    for (int n = 0; n < 40 && v[0]; n++) reg_read(8'h00, v);
    check("R5 commit bit clears", v, 32'h0);
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'hA000_0000 | i;
  endfunction

  function automatic logic [31:0] odata(int k);
    return m_tdata[k*DW +: DW];
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(8'h04, v);  check("R2 sel0 reset", v, 32'h8000_0000);
    reg_read(8'h40, v);  check("R2 sel15 reset", v, 32'h8000_0000);
    settle();
    check("R2 no output valid", 32'(m_tvalid), 32'h0);
    check("R2 no input ready", 32'(s_tready), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    reg_write(8'h04, 32'h3);
    reg_write(8'h18, 32'h7);
    reg_read(8'h18, v); check("R1 sel5 readback", v, 32'h7);
    settle();
    check("R5 staged write not live", 32'(m_tvalid[0]), 32'h0);
    commit_and_wait();
    settle();
    check("R8 out0 data from in3", odata(0), pat(3));
    check("R8 out0 keep", 32'(m_tkeep[0 +: KW]), 32'h3);
    check("R8 out0 user", 32'(m_tuser[0 +: UW]), 32'h3);
    check("R8 out0 last", 32'(m_tlast[0]), 32'h1);
    check("R8 out5 data from in7", odata(5), pat(7));
    check("R3 disabled out1 idle", 32'(m_tvalid[1]), 32'h0);
    check("R7 unclaimed in4 not ready", 32'(s_tready[4]), 32'h0);
    check("R7 claimed in3 ready", 32'(s_tready[3]), 32'h1);
  endtask

  task automatic t_conflict();
    reg_write(8'h0C, 32'h3);
    commit_and_wait();
    settle();
    check("R4 higher out2 idle", 32'(m_tvalid[2]), 32'h0);
    check("R4 lower out0 keeps in3", odata(0), pat(3));
    reg_write(8'h04, 32'h8000_0003);
    commit_and_wait();
    settle();
    check("R3 disabled out0 idle", 32'(m_tvalid[0]), 32'h0);
    check("R4 out2 takes in3", 32'(m_tvalid[2]), 32'h1);
    check("R4 out2 data", odata(2), pat(3));
  endtask

  task automatic t_bad_index();
    logic [31:0] v;
    reg_write(8'h1C, 32'h14);
    reg_read(8'h1C, v); check("R1 sel6 index readback", v, 32'h14);
    commit_and_wait();
    settle();
    check("R3 out-of-range index idle", 32'(m_tvalid[6]), 32'h0);
  endtask

  task automatic t_backpressure();
    @(negedge clk); m_tready[2] = 1'b0;
    @(negedge clk); s_tdata[3*DW +: DW] = 32'h5555_0003;
    settle();
    check("R8 held valid", 32'(m_tvalid[2]), 32'h1);
    check("R8 held data", odata(2), pat(3));
    check("R8 input stalled", 32'(s_tready[3]), 32'h0);
    @(negedge clk); m_tready[2] = 1'b1;
    settle();
    check("R8 new data after release", odata(2), 32'h5555_0003);
    s_tdata[3*DW +: DW] = pat(3);
    settle();
  endtask

  task automatic t_boundary();
    logic [31:0] v;
    @(negedge clk); s_tlast[3] = 1'b0;
    settle();
    reg_write(8'h0C, 32'h9);
    reg_write(8'h00, 32'h1);
    reg_read(8'h00, v); check("R5 pending reads 1", v, 32'h1);
    settle();
    check("R6 old path still carries in3", odata(2), pat(3));
    check("R6 in3 still ready mid-packet", 32'(s_tready[3]), 32'h1);
    @(negedge clk); s_tlast[3] = 1'b1;
    v = 32'h1;
    for (int n = 0; n < 40 && v[0]; n++) reg_read(8'h00, v);
    check("R5 pending clears after TLAST", v, 32'h0);
    settle();
    check("R6 new path in9", odata(2), pat(9));
    check("R7 in3 released", 32'(s_tready[3]), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) begin
      s_tdata[i*DW +: DW] = pat(i);
      s_tkeep[i*KW +: KW] = KW'(i);
      s_tuser[i*UW +: UW] = UW'(i);
    end
    s_tvalid = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_conflict();
    t_bad_index();
    t_backpressure();
    t_boundary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule